// File: doc/BRIEF.md
# Keyclick Square-Wave Burst Generator

This block makes a short square-wave burst that gives audible feedback when a key is pressed. One control write supplies three settings at once: a magnitude, a 3-bit octave code and a 4-bit length code. That same write also starts the burst. The burst alternates between plus and minus the magnitude with equal half-periods. It runs for the programmed number of whole periods and then returns to zero. Both output channels carry the identical sample stream. A busy flag is high while the burst runs and drops by itself when the burst ends. The block needs no converter clocks, so it keeps working when the converters are powered down.

All timing comes from a reference tick, which is a single-cycle pulse on the system clock. At the default scaling, and with a 16 kHz tick, the highest octave code gives 8 kHz and the lowest gives 62.5 Hz. Each step down in the code halves the frequency. A write that arrives while a burst runs discards that burst and starts a fresh one with the new settings. The analog summing into the output path lies outside this block.

Top module: `keyclick_gen`

## Requirements
- R1: While reset is high and after it is released with no write, busy is 0 and both channel outputs are 0.
- R2: In the cycle after a write strobe, busy is 1 and the output equals +magnitude, where wr_amp is an unsigned magnitude.
- R3: For octave code f (wr_freq, 0..7), each half-period lasts HALF_BASE * 2^(7-f) accepted ticks. At HALF_BASE = 1, code 7 gives a half-period of 1 tick and code 0 gives 128 ticks.
- R4: For length code d (wr_dur, 0..15), the burst lasts 2*(d+1) whole periods, which is 4*(d+1) half-periods. Code 0 therefore gives 2 periods and code 15 gives 32.
- R5: During a burst the output alternates +magnitude, -magnitude, +magnitude and so on, starting positive, with every half-period the same length.
- R6: busy falls in the same cycle that the output returns to 0, which is right after the tick that ends the final half-period. When busy is 0 the output is 0.
- R7: The left and right outputs are equal in every cycle.
- R8: A cycle with no tick and no write leaves the output and busy unchanged.
- R9: A write during a burst restarts the burst with the newly written settings. If a tick arrives in the same cycle as the write, the write takes precedence and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference timing pulse, one cycle wide |
| wr_stb | input | 1 | Control write strobe; starts or restarts a burst |
| wr_amp | input | 8 | Unsigned burst magnitude |
| wr_freq | input | 3 | Octave code; frequency doubles per step |
| wr_dur | input | 4 | Length code; 2*(code+1) periods |
| out_left | output | 9 | Signed left sample level |
| out_right | output | 9 | Signed right sample level |
| busy | output | 1 | Burst in progress; clears itself at the end |

## Verification
The bench checks both ends of the octave ladder and of the length range. A shift off by one, or a wrong count of half-periods, would show up as a half-period of the wrong length or an extra or missing segment. Some bursts run with gated ticks and with a held tick, so a design that counted clocks instead of ticks would end its segments early. A restart in mid-burst with a new magnitude and octave catches a design that ignores the write or keeps stale settings. Writes land on tick cycles, which catches a design that lets the tick advance the fresh burst.

// File: rtl/kc_pkg.sv
package kc_pkg;

    localparam int KC_AMP_W  = 8;
    localparam int KC_FREQ_W = 3;
    localparam int KC_DUR_W  = 4;
    localparam int KC_TOP_CODE = (1 << KC_FREQ_W) - 1;
    localparam int KC_SAMP_W = KC_AMP_W + 1;

    typedef enum logic {
        PH_POS = 1'b0,
        PH_NEG = 1'b1
    } kc_phase_e;

    typedef struct packed {
        logic [KC_AMP_W-1:0]  amp;
        logic [KC_FREQ_W-1:0] freq;
        logic [KC_DUR_W-1:0]  dur;
    } kc_cfg_t;

    typedef struct packed {
        logic      busy;
        kc_phase_e ph;
    } kc_state_t;

    // ticks per half-period for an octave code
    function automatic int unsigned kc_half_len(input logic [KC_FREQ_W-1:0] code,
                                                input int unsigned base);
        return base << (KC_TOP_CODE - int'(code));
    endfunction

    // half-periods in a burst for a length code
    function automatic int unsigned kc_halves(input logic [KC_DUR_W-1:0] code);
        return 4 * (int'(code) + 1);
    endfunction

endpackage

// File: rtl/kc_cfg_reg.sv
module kc_cfg_reg
    import kc_pkg::*;
#(
    parameter int HALF_BASE = 1,
    parameter int CNT_W     = 8,
    parameter int HC_W      = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  kc_cfg_t          cfg_in,
    output kc_cfg_t          cfg_q,
    output logic [CNT_W-1:0] half_len_q,
    output logic [HC_W-1:0]  halves_q
);

    logic [CNT_W-1:0] half_len_d;
    logic [HC_W-1:0]  halves_d;

    always_comb begin
        half_len_d = CNT_W'(kc_half_len(cfg_in.freq, HALF_BASE));
        halves_d   = HC_W'(kc_halves(cfg_in.dur));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            half_len_q <= CNT_W'(1);
            halves_q   <= '0;
        end else if (wr) begin
            cfg_q      <= cfg_in;
            half_len_q <= half_len_d;
            halves_q   <= halves_d;
        end
    end

endmodule

// File: rtl/kc_timer.sv
module kc_timer
    import kc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int HC_W  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             tick,
    input  logic [CNT_W-1:0] half_len,
    input  logic [HC_W-1:0]  halves,
    output kc_state_t        st
);

    logic [CNT_W-1:0] tcnt;
    logic [HC_W-1:0]  hcnt;
    logic             step;
    logic             end_half;
    logic             end_burst;

    always_comb begin
        step      = st.busy && tick && !wr;
        end_half  = (tcnt == half_len - CNT_W'(1));
        end_burst = end_half && (hcnt == halves - HC_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.busy <= 1'b0;
            st.ph   <= PH_POS;
            tcnt    <= '0;
            hcnt    <= '0;
        end else if (wr) begin
            // a write always wins: fresh burst, positive first
            st.busy <= 1'b1;
            st.ph   <= PH_POS;
            tcnt    <= '0;
            hcnt    <= '0;
        end else if (step) begin
            if (end_burst) begin
                st.busy <= 1'b0;
                st.ph   <= PH_POS;
                tcnt    <= '0;
                hcnt    <= '0;
            end else if (end_half) begin
                tcnt  <= '0;
                hcnt  <= hcnt + HC_W'(1);
                st.ph <= (st.ph == PH_POS) ? PH_NEG : PH_POS;
            end else begin
                tcnt <= tcnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/kc_level.sv
module kc_level
    import kc_pkg::*;
#(
    parameter int NCH = 2
) (
    input  kc_state_t                         st,
    input  logic [KC_AMP_W-1:0]               amp,
    output logic signed [NCH-1:0][KC_SAMP_W-1:0] lvl
);

    logic signed [KC_SAMP_W-1:0] pos_l;
    logic signed [KC_SAMP_W-1:0] neg_l;

    always_comb begin
        pos_l = $signed({1'b0, amp});
        neg_l = -pos_l;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        always_comb begin
            if (!st.busy)
                lvl[ch] = '0;
            else if (st.ph == PH_POS)
                lvl[ch] = pos_l;
            else
                lvl[ch] = neg_l;
        end
    end

endmodule

// File: rtl/keyclick_gen.sv
module keyclick_gen
    import kc_pkg::*;
#(
    parameter int HALF_BASE = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick,
    input  logic                        wr_stb,
    input  logic [KC_AMP_W-1:0]         wr_amp,
    input  logic [KC_FREQ_W-1:0]        wr_freq,
    input  logic [KC_DUR_W-1:0]         wr_dur,
    output logic signed [KC_SAMP_W-1:0] out_left,
    output logic signed [KC_SAMP_W-1:0] out_right,
    output logic                        busy
);

    localparam int NCH   = 2;
    localparam int CNT_W = $clog2(HALF_BASE * (1 << KC_TOP_CODE) + 1);
    localparam int HC_W  = $clog2(4 * (1 << KC_DUR_W) + 1);

    kc_cfg_t                              cfg_in;
    kc_cfg_t                              cfg_q;
    logic [CNT_W-1:0]                     half_len_q;
    logic [HC_W-1:0]                      halves_q;
    kc_state_t                            st;
    logic signed [NCH-1:0][KC_SAMP_W-1:0] lvl;

    always_comb begin
        cfg_in.amp  = wr_amp;
        cfg_in.freq = wr_freq;
        cfg_in.dur  = wr_dur;
    end

    kc_cfg_reg #(
        .HALF_BASE (HALF_BASE),
        .CNT_W     (CNT_W),
        .HC_W      (HC_W)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr_stb),
        .cfg_in     (cfg_in),
        .cfg_q      (cfg_q),
        .half_len_q (half_len_q),
        .halves_q   (halves_q)
    );

    kc_timer #(
        .CNT_W (CNT_W),
        .HC_W  (HC_W)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_stb),
        .tick     (tick),
        .half_len (half_len_q),
        .halves   (halves_q),
        .st       (st)
    );

    kc_level #(
        .NCH (NCH)
    ) u_lvl (
        .st  (st),
        .amp (cfg_q.amp),
        .lvl (lvl)
    );

    assign out_left  = lvl[0];
    assign out_right = lvl[1];
    assign busy      = st.busy;

endmodule

// File: rtl/kc_chk.sv
module kc_chk
    import kc_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        tick,
    input logic                        wr_stb,
    input logic [KC_AMP_W-1:0]         wr_amp,
    input logic signed [KC_SAMP_W-1:0] out_left,
    input logic signed [KC_SAMP_W-1:0] out_right,
    input logic                        busy
);

    // R7
    lr_match_chk: assert property (@(posedge clk) disable iff (rst)
        out_left == out_right);

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> out_left == '0);

    // R2
    start_pos_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> busy && out_left == $signed({1'b0, $past(wr_amp)}));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick && !wr_stb) |=> busy && $stable(out_left));

    // R5
    swing_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_stb) |=> (!busy || out_left == $past(out_left)
                               || out_left == -$past(out_left)));

endmodule

bind keyclick_gen kc_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .wr_stb    (wr_stb),
    .wr_amp    (wr_amp),
    .out_left  (out_left),
    .out_right (out_right),
    .busy      (busy)
);

// File: tb/sim_keyclick_gen.sv
module sim_keyclick_gen;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              wr_stb = 1'b0;
    logic [7:0]        wr_amp = '0;
    logic [2:0]        wr_freq = '0;
    logic [3:0]        wr_dur = '0;
    logic signed [8:0] out_left;
    logic signed [8:0] out_right;
    logic              busy;

    localparam int HALF_BASE = 1;

    keyclick_gen #(.HALF_BASE(HALF_BASE)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .wr_stb(wr_stb),
        .wr_amp(wr_amp), .wr_freq(wr_freq), .wr_dur(wr_dur),
        .out_left(out_left), .out_right(out_right), .busy(busy)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    lvl;
        int    len;
        bit    chk_lvl;
        bit    chk_len;
        string req;
    } seg_t;

    seg_t q[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   tick_mode = 0;   // 0 every cycle, 1 gated pattern, 2 off
    int   cyc = 0;
    bit   mon_on = 0;
    bit   done = 0;

    // tick source
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (tick_mode == 0)      tick <= 1'b1;
        else if (tick_mode == 1) tick <= (cyc % 3 != 0);
        else                     tick <= 1'b0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic seg_t mk(input int lvl, input int len, input bit cl,
                                input bit cn, input string req);
        seg_t s;
        s.lvl = lvl; s.len = len; s.chk_lvl = cl; s.chk_len = cn; s.req = req;
        return s;
    endfunction

    // driver: pushes expected segments, then issues the write
    task automatic burst(input int a, input int f, input int d, input bit restart);
        int hl;
        int nh;
        hl = HALF_BASE << (7 - f);          // R3
        nh = 4 * (d + 1);                   // R4
        @(negedge clk);
        if (restart) begin                  // R9: current segment cut short
            q.delete();
            q.push_back(mk(0, 0, 0, 0, "R9"));
        end
        for (int i = 0; i < nh; i++)        // R5: positive first, alternating
            q.push_back(mk((i % 2 == 0) ? a : -a, hl, 1, 1, "R3/R4/R5"));
        q.push_back(mk(0, 0, 1, 0, "R6"));
        wr_amp  = 8'(a);
        wr_freq = 3'(f);
        wr_dur  = 4'(d);
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
        // R2: one cycle after the write, busy and +magnitude
        check(busy === 1'b1 && out_left == 9'(a), "R2", int'(out_left), a);
    endtask

    task automatic wait_idle();
        while (busy === 1'b1) @(negedge clk);
        check(out_left == 0 && out_right == 0, "R6", int'(out_left), 0);
    endtask

    // monitor: measures segments and pops expected items
    initial begin
        int run = 0;
        int last = 0;
        bit lr_bad = 0;
        bit bz_bad = 0;
        seg_t s;
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                run += int'(tick);
                if (out_left != out_right) lr_bad = 1;
                if (busy !== (out_left != 0)) bz_bad = 1;
                if (int'(out_left) != last) begin
                    if (q.size() == 0) begin
                        check(0, "R4 extra segment", int'(out_left), last);
                    end else begin
                        s = q.pop_front();
                        check(!s.chk_lvl || s.lvl == last, {s.req, " level"}, last, s.lvl);
                        check(!s.chk_len || s.len == run, {s.req, " ticks"}, run, s.len);
                    end
                    check(!lr_bad, "R7 left/right", int'(lr_bad), 0);
                    check(!bz_bad, "R6 busy vs level", int'(bz_bad), 0);
                    lr_bad = 0;
                    bz_bad = 0;
                    last = int'(out_left);
                    run = 0;
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        // R1: during reset
        check(busy === 1'b0 && out_left == 0 && out_right == 0, "R1", int'(busy), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1: after reset with no write
        check(busy === 1'b0 && out_left == 0, "R1", int'(out_left), 0);
        q.push_back(mk(0, 0, 1, 0, "R1"));
        mon_on = 1;

        // highest octave, shortest length
        burst(100, 7, 0, 0);
        wait_idle();
        // lowest octave
        burst(5, 0, 0, 0);
        wait_idle();
        // longest length, gated ticks, largest magnitude
        tick_mode = 1;
        burst(255, 3, 15, 0);
        wait_idle();
        // R8: ticks held off mid-burst
        burst(1, 5, 2, 0);
        repeat (20) @(negedge clk);
        tick_mode = 2;
        @(negedge clk);
        held = int'(out_left);
        repeat (25) @(negedge clk);
        check(busy === 1'b1 && int'(out_left) == held, "R8", int'(out_left), held);
        tick_mode = 1;
        wait_idle();
        // R9: restart mid-burst with new settings
        tick_mode = 0;
        burst(50, 6, 1, 0);
        repeat (10) @(negedge clk);
        burst(80, 4, 0, 1);
        wait_idle();
        repeat (5) @(negedge clk);
        // R4: only the trailing idle item may remain
        check(q.size() == 1, "R4 segment count", q.size(), 1);
        finish_run();
    end

endmodule